// File: doc/BRIEF.md
# Two-Way Set-Associative Cache Controller

This block is a write-through cache that sits between a processor and a word-addressed main memory. With the default parameters it takes a 16-bit word address and holds 2048 words. These are organised as 128 lines of 16 words, arranged in 64 sets of two ways. The address splits into three fields: a 6-bit tag in bits 15:10, a 6-bit set index in bits 9:4 and a 4-bit word offset in bits 3:0. A lookup compares the request tag against both ways of the selected set at the same time.

On the processor side a request is held until the cache answers with a one-cycle ready pulse. A read hit is served from the data store. A read miss fetches the whole line from memory, then returns the requested word. Every write is forwarded to memory through a single-word write port. A write that hits also updates the cached copy. A write that misses leaves the cache untouched. Victim selection uses one valid bit per way and one least-recently-used bit per set.

Top module: `cache2w`

## Requirements
- R1: After reset no line is valid, cpu_ready is low and neither memory request is asserted, so the first read of any address misses.
- R2: The address splits as tag = addr[15:10], set = addr[9:4] and word = addr[3:0]. Blocks whose block numbers are equal modulo 64 compete for the same set.
- R3: A read hit raises cpu_ready for exactly one cycle, in the cycle after the request is accepted, with the stored word on cpu_rdata. No memory read takes place.
- R4: A read miss holds mem_rd_req high with mem_rd_addr set to the block base, whose word bits are zero. It then consumes exactly 16 words on mem_rd_valid, in offset order 0 to 15. Gaps between the words are allowed.
- R5: During a refill cpu_ready stays low. It rises in the cycle after the last word is taken, and cpu_rdata then carries the requested word.
- R6: Once a line has been refilled, later reads of any word in it hit while the line stays resident.
- R7: Each set can hold two different blocks at the same time, one in each way. A tag never matches in both ways.
- R8: On a miss an invalid way is filled first. Otherwise the least recently used way is replaced. A hit or a fill makes the way it touched the most recently used one.
- R9: Every write causes exactly one memory write with the request's address and data. cpu_ready follows in the cycle after mem_wr_ack.
- R10: A write hit updates the cached word, so a later read returns the new value without a refill.
- R11: A write miss does not allocate a line, so a later read of that block misses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Word address |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid with cpu_ready on reads |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_rd_req | output | 1 | Line refill request, held for the whole refill |
| mem_rd_addr | output | 16 | Block base address of the refill |
| mem_rd_valid | input | 1 | A refill word is present this cycle |
| mem_rd_data | input | 32 | Refill word |
| mem_wr_req | output | 1 | Write-through request, held until acknowledged |
| mem_wr_addr | output | 16 | Write-through address |
| mem_wr_data | output | 32 | Write-through data |
| mem_wr_ack | input | 1 | Write accepted by memory |

## Verification
The bench uses a reduced configuration with four sets and four-word lines. It runs a reference memory and its own model of tags, valid bits and LRU bits. A linear read sweep over the whole address space separates first-touch misses from hits in the same line, and it also checks the block base and word order of each refill. A pattern of three blocks aimed at one set separates true LRU replacement from any fixed or round-robin choice of way. A write sweep over every address, followed by a read-back sweep, separates write hits that update the cache from write misses that only reach memory. A write to a block that is not resident, followed by a read of that block, shows whether a write miss allocates a line.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;

    localparam int unsigned NUM_WAYS = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_WRITE,
        ST_RESP
    } ctl_state_e;

    // an empty way wins; with both full the LRU bit names the way to evict
    function automatic logic pick_victim(input logic vld0, input logic vld1, input logic lru);
        if (!vld0) return 1'b0;
        if (!vld1) return 1'b1;
        return lru;
    endfunction

endpackage

// File: rtl/cache2w_tags.sv
module cache2w_tags
    import cache2w_pkg::*;
#(
    parameter int unsigned TAG_W = 6,
    parameter int unsigned SET_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] lk_set,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             hit,
    output logic             hit_way,
    output logic             victim_way,
    input  logic             touch_en,
    input  logic [SET_W-1:0] touch_set,
    input  logic             touch_way,
    input  logic             fill_en,
    input  logic [SET_W-1:0] fill_set,
    input  logic             fill_way,
    input  logic [TAG_W-1:0] fill_tag
);
    localparam int unsigned SETS = 1 << SET_W;

    logic [NUM_WAYS-1:0] way_hit;
    logic [NUM_WAYS-1:0] way_vld;
    logic [SETS-1:0]     lru_q;   // way to evict next

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        logic [TAG_W-1:0] tag_q [SETS];
        logic [SETS-1:0]  vld_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q <= '0;
            end else if (fill_en && (fill_way == 1'(w))) begin
                vld_q[fill_set] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (fill_en && (fill_way == 1'(w))) begin
                tag_q[fill_set] <= fill_tag;
            end
        end

        assign way_vld[w] = vld_q[lk_set];
        assign way_hit[w] = vld_q[lk_set] && (tag_q[lk_set] == lk_tag);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lru_q <= '0;
        end else if (touch_en) begin
            lru_q[touch_set] <= ~touch_way;
        end
    end

    assign hit        = |way_hit;
    assign hit_way    = way_hit[1];
    assign victim_way = pick_victim(way_vld[0], way_vld[1], lru_q[lk_set]);

    // R7: a block is resident in at most one way of its set
    p_hit_onehot0_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(way_hit));

endmodule

// File: rtl/cache2w_data.sv
module cache2w_data #(
    parameter int unsigned SET_W  = 6,
    parameter int unsigned OFF_W  = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic                        clk,
    input  logic [SET_W+OFF_W:0]        rd_idx,
    output logic [DATA_W-1:0]           rd_data,
    input  logic                        we,
    input  logic [SET_W+OFF_W:0]        wr_idx,
    input  logic [DATA_W-1:0]           wr_data
);
    localparam int unsigned IDX_W = SET_W + OFF_W + 1;
    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store_q[wr_idx] <= wr_data;
        end
    end

    assign rd_data = store_q[rd_idx];

endmodule

// File: rtl/cache2w.sv
module cache2w
    import cache2w_pkg::*;
#(
    parameter int unsigned TAG_W  = 6,
    parameter int unsigned SET_W  = 6,
    parameter int unsigned OFF_W  = 4,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned ADDR_W = TAG_W + SET_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_wr_req,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    input  logic              mem_wr_ack
);
    localparam int unsigned IDX_W = SET_W + OFF_W + 1;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } req_t;

    ctl_state_e        state_q;
    req_t              req_q;
    logic              way_q;
    logic [OFF_W-1:0]  beat_q;
    logic [DATA_W-1:0] rdata_q;

    // fields of the live request and of the latched one
    logic [TAG_W-1:0] c_tag, r_tag;
    logic [SET_W-1:0] c_set, r_set;
    logic [OFF_W-1:0] c_off, r_off;

    assign c_tag = cpu_addr[ADDR_W-1 -: TAG_W];
    assign c_set = cpu_addr[OFF_W +: SET_W];
    assign c_off = cpu_addr[OFF_W-1:0];
    assign r_tag = req_q.addr[ADDR_W-1 -: TAG_W];
    assign r_set = req_q.addr[OFF_W +: SET_W];
    assign r_off = req_q.addr[OFF_W-1:0];

    logic hit, hit_way, victim_way;
    logic accept, in_fill, fill_beat, fill_last;

    assign accept    = (state_q == ST_IDLE) && cpu_req;
    assign in_fill   = (state_q == ST_FILL);
    assign fill_beat = in_fill && mem_rd_valid;
    assign fill_last = fill_beat && (&beat_q);

    cache2w_tags #(
        .TAG_W (TAG_W),
        .SET_W (SET_W)
    ) u_tags (
        .clk        (clk),
        .rst        (rst),
        .lk_set     (c_set),
        .lk_tag     (c_tag),
        .hit        (hit),
        .hit_way    (hit_way),
        .victim_way (victim_way),
        .touch_en   ((accept && hit) || fill_last),
        .touch_set  (fill_last ? r_set : c_set),
        .touch_way  (fill_last ? way_q : hit_way),
        .fill_en    (fill_last),
        .fill_set   (r_set),
        .fill_way   (way_q),
        .fill_tag   (r_tag)
    );

    logic [DATA_W-1:0] store_rd;
    logic [IDX_W-1:0]  hit_idx;
    logic [IDX_W-1:0]  fill_idx;

    assign hit_idx  = {c_set, hit_way, c_off};
    assign fill_idx = {r_set, way_q, beat_q};

    cache2w_data #(
        .SET_W  (SET_W),
        .OFF_W  (OFF_W),
        .DATA_W (DATA_W)
    ) u_data (
        .clk     (clk),
        .rd_idx  (hit_idx),
        .rd_data (store_rd),
        .we      ((accept && cpu_we && hit) || fill_beat),
        .wr_idx  (in_fill ? fill_idx : hit_idx),
        .wr_data (in_fill ? mem_rd_data : cpu_wdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            req_q   <= '0;
            way_q   <= 1'b0;
            beat_q  <= '0;
            rdata_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cpu_req) begin
                        req_q <= '{we: cpu_we, addr: cpu_addr, wdata: cpu_wdata};
                        if (cpu_we) begin
                            state_q <= ST_WRITE;
                        end else if (hit) begin
                            rdata_q <= store_rd;
                            state_q <= ST_RESP;
                        end else begin
                            way_q   <= victim_way;
                            beat_q  <= '0;
                            state_q <= ST_FILL;
                        end
                    end
                end
                ST_FILL: begin
                    if (mem_rd_valid) begin
                        beat_q <= beat_q + 1'b1;
                        if (beat_q == r_off) rdata_q <= mem_rd_data;
                        if (&beat_q) state_q <= ST_RESP;
                    end
                end
                ST_WRITE: begin
                    if (mem_wr_ack) state_q <= ST_RESP;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign cpu_ready   = (state_q == ST_RESP);
    assign cpu_rdata   = rdata_q;
    assign mem_rd_req  = in_fill;
    assign mem_rd_addr = {r_tag, r_set, {OFF_W{1'b0}}};
    assign mem_wr_req  = (state_q == ST_WRITE);
    assign mem_wr_addr = req_q.addr;
    assign mem_wr_data = req_q.wdata;

    // R3: the completion is a single-cycle pulse
    p_ready_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |=> !cpu_ready);

    // R4: the refill address does not move while the refill runs
    p_rd_addr_stable_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_req && $past(mem_rd_req)) |-> $stable(mem_rd_addr));

    // R5: the last refill word is followed by the completion
    p_fill_last_ready_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_req && mem_rd_valid && (&beat_q)) |=> cpu_ready);

    // R9: an acknowledged write-through completes the request
    p_wr_ack_ready_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_req && mem_wr_ack) |=> cpu_ready);

endmodule

// File: tb/cache2w_bench.sv
module cache2w_bench;

    localparam int TAG_W  = 3;
    localparam int SET_W  = 2;
    localparam int OFF_W  = 2;
    localparam int DATA_W = 16;
    localparam int ADDR_W = TAG_W + SET_W + OFF_W;
    localparam int MEM_N  = 1 << ADDR_W;
    localparam int SETS   = 1 << SET_W;
    localparam int WORDS  = 1 << OFF_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cpu_req = 1'b0;
    logic              cpu_we = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [DATA_W-1:0] cpu_wdata = '0;
    logic [DATA_W-1:0] cpu_rdata;
    logic              cpu_ready;
    logic              mem_rd_req;
    logic [ADDR_W-1:0] mem_rd_addr;
    logic              mem_rd_valid = 1'b0;
    logic [DATA_W-1:0] mem_rd_data = '0;
    logic              mem_wr_req;
    logic [ADDR_W-1:0] mem_wr_addr;
    logic [DATA_W-1:0] mem_wr_data;
    logic              mem_wr_ack = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    cache2w #(
        .TAG_W (TAG_W), .SET_W (SET_W), .OFF_W (OFF_W), .DATA_W (DATA_W)
    ) u_cache2w (
        .clk, .rst, .cpu_req, .cpu_we, .cpu_addr, .cpu_wdata, .cpu_rdata, .cpu_ready,
        .mem_rd_req, .mem_rd_addr, .mem_rd_valid, .mem_rd_data,
        .mem_wr_req, .mem_wr_addr, .mem_wr_data, .mem_wr_ack
    );

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    // memory as the cache sees it, and the value a read must return
    logic [DATA_W-1:0] mem_model [MEM_N];
    logic [DATA_W-1:0] ref_mem   [MEM_N];

    // reference tag state
    logic [TAG_W-1:0] m_tag [SETS][2];
    bit               m_vld [SETS][2];
    bit               m_lru [SETS];

    int                rd_cnt = 0;
    int                beats_total = 0;
    int                wr_total = 0;
    bit                stall_tog = 0;
    logic [ADDR_W-1:0] fill_base = '0;
    logic [ADDR_W-1:0] last_wr_addr = '0;

    // memory responder: streams a line with a gap every other cycle
    always @(negedge clk) begin
        if (!mem_rd_req) begin
            rd_cnt       = 0;
            mem_rd_valid = 1'b0;
        end else begin
            stall_tog = ~stall_tog;
            if (rd_cnt < WORDS && !stall_tog) begin
                if (rd_cnt == 0) fill_base = mem_rd_addr;
                mem_rd_valid = 1'b1;
                mem_rd_data  = mem_model[mem_rd_addr + ADDR_W'(rd_cnt)];
                rd_cnt++;
                beats_total++;
            end else begin
                mem_rd_valid = 1'b0;
            end
        end
        if (mem_wr_req && !mem_wr_ack) begin
            mem_wr_ack   = 1'b1;
            mem_model[mem_wr_addr] = mem_wr_data;
            last_wr_addr = mem_wr_addr;
            wr_total++;
        end else begin
            mem_wr_ack = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // model lookup; updates tags/LRU the way the requirements say
    task automatic model_access(input bit we, input logic [ADDR_W-1:0] a, output bit hit);
        int s = int'(a[OFF_W +: SET_W]);
        logic [TAG_W-1:0] t = a[ADDR_W-1 -: TAG_W];
        int w = -1;
        for (int k = 0; k < 2; k++) if (m_vld[s][k] && m_tag[s][k] == t) w = k;
        hit = (w >= 0);
        if (hit) begin
            m_lru[s] = (w == 0);
        end else if (!we) begin
            if (!m_vld[s][0]) w = 0;
            else if (!m_vld[s][1]) w = 1;
            else w = int'(m_lru[s]);
            m_vld[s][w] = 1;
            m_tag[s][w] = t;
            m_lru[s] = (w == 0);
        end
    endtask

    task automatic do_op(input bit we, input logic [ADDR_W-1:0] a,
                         input logic [DATA_W-1:0] wd, input string grp);
        bit hit;
        int lat = 0;
        int b0 = beats_total;
        int w0 = wr_total;
        model_access(we, a, hit);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        forever begin
            @(negedge clk);
            lat++;
            if (cpu_ready || lat > 400) break;
        end
        cpu_req = 1'b0;
        if (!cpu_ready) begin
            chk(0, grp, "no ready", lat, 0);
            return;
        end
        if (!we) begin
            chk(cpu_rdata == ref_mem[a], hit ? "R3" : "R5", {grp, " read data"},
                int'(cpu_rdata), int'(ref_mem[a]));
            chk((beats_total - b0) == (hit ? 0 : WORDS), hit ? "R6" : "R4",
                {grp, " refill words"}, beats_total - b0, hit ? 0 : WORDS);
            if (hit) chk(lat == 1, "R3", {grp, " hit latency"}, lat, 1);
            else chk(fill_base == {a[ADDR_W-1:OFF_W], {OFF_W{1'b0}}}, "R2/R4",
                     {grp, " refill base"}, int'(fill_base),
                     int'({a[ADDR_W-1:OFF_W], {OFF_W{1'b0}}}));
        end else begin
            ref_mem[a] = wd;
            chk((wr_total - w0) == 1, "R9", {grp, " write count"}, wr_total - w0, 1);
            chk(last_wr_addr == a && mem_model[a] == wd, "R9", {grp, " write addr/data"},
                int'(mem_model[a]), int'(wd));
            chk(beats_total == b0, "R11", {grp, " no refill on write"}, beats_total - b0, 0);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            vectors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin : main
        bit h;
        for (int i = 0; i < MEM_N; i++) begin
            mem_model[i] = DATA_W'(i * 41 + 4660);
            ref_mem[i]   = mem_model[i];
        end
        for (int s = 0; s < SETS; s++) begin
            m_vld[s][0] = 0; m_vld[s][1] = 0; m_lru[s] = 0;
            m_tag[s][0] = '0; m_tag[s][1] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle outputs after reset
        chk(!cpu_ready, "R1", "ready after reset", int'(cpu_ready), 0);
        chk(!mem_rd_req && !mem_wr_req, "R1", "mem requests after reset",
            int'({mem_rd_req, mem_wr_req}), 0);

        // linear read sweep: first touch of each line misses (R1, R4, R5, R6)
        for (int i = 0; i < MEM_N; i++) do_op(0, ADDR_W'(i), '0, "sweep-read");

        // three blocks in set 1: LRU replacement and two resident ways (R7, R8)
        for (int r = 0; r < 2; r++) begin
            do_op(0, ADDR_W'((1 << OFF_W) + 0),           '0, "R7 blk-A");
            do_op(0, ADDR_W'((1 << OFF_W) + (SETS << OFF_W) + 1), '0, "R7 blk-B");
            do_op(0, ADDR_W'((1 << OFF_W) + 2),           '0, "R8 blk-A again");
            do_op(0, ADDR_W'((1 << OFF_W) + (2 * SETS << OFF_W) + 3), '0, "R8 blk-C evicts");
            do_op(0, ADDR_W'((1 << OFF_W) + 1),           '0, "R8 blk-A kept");
            do_op(0, ADDR_W'((1 << OFF_W) + (SETS << OFF_W) + 2), '0, "R8 blk-B back");
        end

        // write every address, then read back (R9, R10, R11)
        for (int i = 0; i < MEM_N; i++)
            do_op(1, ADDR_W'(i), DATA_W'(i * 7 + 99), "R10 sweep-write");
        for (int i = 0; i < MEM_N; i++) do_op(0, ADDR_W'(i), '0, "R10 read-back");

        // a write miss must not allocate: next read of that block misses (R11)
        for (int b = 0; b < MEM_N / WORDS; b++) begin
            logic [ADDR_W-1:0] a = ADDR_W'(b * WORDS + 1);
            bit res = 0;
            int s = int'(a[OFF_W +: SET_W]);
            for (int k = 0; k < 2; k++)
                if (m_vld[s][k] && m_tag[s][k] == a[ADDR_W-1 -: TAG_W]) res = 1;
            if (!res) begin
                do_op(1, a, 16'h5a5a, "R11 write-miss");
                model_access(0, a, h);
                chk(!h, "R11", "model shows miss", int'(h), 0);
                // undo the model update so do_op predicts from the same state
                for (int k = 0; k < 2; k++)
                    if (m_tag[s][k] == a[ADDR_W-1 -: TAG_W]) m_vld[s][k] = 0;
                m_lru[s] = ~m_lru[s];
                do_op(0, a, '0, "R11 read-after-write-miss");
                break;
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule